// File: doc/BRIEF.md
# Selectable-Ratio Synchronous Clock Divider

The block turns one input clock into three slower clocks taken from a single shared counter, so every output changes on the same input edge and the rising edges the outputs have in common coincide. A ratio-select input picks one of two sets: with it low the outputs run at one half, one quarter and one eighth of the input rate; with it high the whole set moves up one binary step to a pass-through, one half and one quarter.

A hold input stops the internal clock without ever cutting a pulse short. It is sampled on the falling edge of the input clock, so the gate opens or closes only while the clock is low. While held, the counter keeps its value, and when the hold is dropped counting resumes from that value. A master reset clears the counter and all outputs at once, whatever the hold input does. Its release is taken on a falling edge, so the first rising edge after release is a clean first count. Several instances that share clock and reset therefore stay in phase.

A small gate controller with three states decides whether the internal clock runs. Its states are GS_RESET (reset active, gate shut), GS_RUN (gate open) and GS_HOLD (gate shut, state kept). Its transitions, all taken on the falling edge, are: GS_RESET to GS_RUN when hold is low, GS_RESET to GS_HOLD when hold is high, GS_RUN to GS_HOLD when hold rises, GS_HOLD to GS_RUN when hold falls, and any state to GS_RESET at once when the master reset is high.

Top module: `clkdiv_ratio_sel`

## Requirements
- R1: With ratio_sel low, div_out[0], div_out[1] and div_out[2] have periods of 2, 4 and 8 input clocks. After the k-th counted rising edge since reset, div_out[i] equals bit i of (8 - k) mod 8.
- R2: With ratio_sel high, div_out[0] follows clk_in while the gate is open and is low while it is shut. div_out[1] and div_out[2] equal bits 0 and 1 of (8 - k) mod 8.
- R3: The outputs rise together. At the first counted edge after reset, and at every eighth counted edge after that, all three outputs go high on the same input edge.
- R4: hold_req is sampled on the falling edge of clk_in. When it is high at a falling edge, no count happens on the next rising edge and all outputs keep their levels.
- R5: When a hold ends, counting resumes from the held value, as if the held cycles had never occurred.
- R6: master_rst high forces all outputs and the counter to zero at once, whatever hold_req is.
- R7: The release of master_rst takes effect on the next falling edge of clk_in. The first count happens on the rising edge that follows that falling edge.
- R8: The gate opens and closes only while clk_in is low. No pulse of the pass-through output is shorter than half an input period.
- R9: A change of ratio_sel made while master_rst is high gives the new ratio set from the first count after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| master_rst | input | 1 | Master reset, active high. Asserts at once and is released on a falling edge. |
| hold_req | input | 1 | Hold request, active high, sampled on the falling edge |
| ratio_sel | input | 1 | Ratio set: 0 gives 2/4/8, 1 gives 1/2/4 |
| div_out | output | 3 | Divided clock outputs, index 0 being the fastest |

## Verification
The bench holds the clock while it is high, which is the point where a gate that reacts straight to the hold input would chop the pass-through pulse. It measures every high pulse of that output, so a design that gates the clock without the falling-edge sample shows up as a runt. Each hold run is followed by a check of the count that continues from the held value, which catches a design that loses or adds a count around the freeze. It applies the reset with hold high, and releases the reset both with hold low and with hold high. A design that starts counting on the edge of release, or that lets hold block the reset, then gives the wrong first value. It also changes the ratio set while in reset, so a wrong output mapping shows up at once.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // One-hot gate controller state
    typedef enum logic [2:0] {
        GS_RESET = 3'b001,
        GS_RUN   = 3'b010,
        GS_HOLD  = 3'b100
    } gate_state_e;

    // Ratio set picked by the select input
    typedef enum logic {
        RATIO_SLOW = 1'b0,   // 2 / 4 / 8
        RATIO_FAST = 1'b1    // 1 / 2 / 4
    } ratio_set_e;

endpackage

// File: rtl/clkdiv_gate_fsm.sv
module clkdiv_gate_fsm
    import clkdiv_pkg::*;
(
    input  logic clk_in,
    input  logic master_rst,
    input  logic hold_req,
    output logic gate_open,
    output logic gclk
);

    gate_state_e state_q;
    gate_state_e state_d;

    // State register: falling edge, reset asserts at once
    always_ff @(negedge clk_in or posedge master_rst) begin
        if (master_rst) begin
            state_q <= GS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RESET: state_d = hold_req ? GS_HOLD : GS_RUN;
            GS_RUN:   state_d = hold_req ? GS_HOLD : GS_RUN;
            GS_HOLD:  state_d = hold_req ? GS_HOLD : GS_RUN;
            default:  state_d = GS_RESET;
        endcase
    end

    // Output logic: gate is open only in GS_RUN
    always_comb begin
        gate_open = 1'b0;
        unique case (state_q)
            GS_RUN:   gate_open = 1'b1;
            GS_RESET,
            GS_HOLD:  gate_open = 1'b0;
            default:  gate_open = 1'b0;
        endcase
    end

    assign gclk = clk_in & gate_open;

    // The gate may change only while the input clock is low (outside reset)
    always @(gate_open) begin
        if (!master_rst && !$isunknown(gate_open)) begin
            assert_gate_moves_low_R8: assert (clk_in == 1'b0)
                else $error("gate changed while clk_in high");
        end
    end

    // The state register never holds more than one state at a time
    assert_state_onehot_R4: assert property (@(negedge clk_in)
        $onehot0(state_q));

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int CNT_W = 3
) (
    input  logic             gclk,
    input  logic             master_rst,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // Down counter: 0 -> all ones makes every bit rise together
    always_ff @(posedge gclk or posedge master_rst) begin
        if (master_rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt - STEP;
        end
    end

endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             gclk,
    input  logic             ratio_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] div_out
);

    ratio_set_e set_sel;
    assign set_sel = ratio_set_e'(ratio_sel);

    for (genvar i = 0; i < CNT_W; i++) begin : g_tap
        if (i == 0) begin : g_first
            // fast set: pass-through of gated clock
            assign div_out[i] = (set_sel == RATIO_FAST) ? gclk : cnt[i];
        end else begin : g_rest
            assign div_out[i] = (set_sel == RATIO_FAST) ? cnt[i-1] : cnt[i];
        end
    end

endmodule

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel #(
    parameter int NUM_OUT = 3
) (
    input  logic               clk_in,
    input  logic               master_rst,
    input  logic               hold_req,
    input  logic               ratio_sel,
    output logic [NUM_OUT-1:0] div_out
);

    localparam int CNT_W = NUM_OUT;

    logic             gate_open;
    logic             gclk;
    logic [CNT_W-1:0] cnt;

    clkdiv_gate_fsm u_gate (
        .clk_in     (clk_in),
        .master_rst (master_rst),
        .hold_req   (hold_req),
        .gate_open  (gate_open),
        .gclk       (gclk)
    );

    clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .gclk       (gclk),
        .master_rst (master_rst),
        .cnt        (cnt)
    );

    clkdiv_outsel #(.CNT_W(CNT_W)) u_sel (
        .gclk       (gclk),
        .ratio_sel  (ratio_sel),
        .cnt        (cnt),
        .div_out    (div_out)
    );

    // Open gate at the previous falling edge: exactly one count since then
    assert_one_step_R5: assert property (@(negedge clk_in) disable iff (master_rst)
        gate_open |-> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // Shut gate: counter frozen
    assert_frozen_R4: assert property (@(negedge clk_in) disable iff (master_rst)
        !gate_open |-> $stable(cnt));

    // Slowest output rising means every output rose with it
    assert_common_rise_R3: assert property (@(negedge clk_in) disable iff (master_rst)
        (!ratio_sel && $rose(div_out[NUM_OUT-1])) |-> (&div_out));

    // Reset wins over hold and forces outputs low
    assert_reset_clears_R6: assert property (@(posedge clk_in)
        master_rst |-> (div_out == '0));

endmodule

// File: tb/test_clkdiv_ratio_sel.sv
module test_clkdiv_ratio_sel;

    logic       clk_in     = 1'b0;
    logic       master_rst = 1'b1;
    logic       hold_req   = 1'b0;
    logic       ratio_sel  = 1'b0;
    logic [2:0] div_out;

    int checks   = 0;
    int failures = 0;
    int k        = 0;

    always #5 clk_in = ~clk_in;   // 100 MHz

    clkdiv_ratio_sel i_clkdiv_ratio_sel (
        .clk_in     (clk_in),
        .master_rst (master_rst),
        .hold_req   (hold_req),
        .ratio_sel  (ratio_sel),
        .div_out    (div_out)
    );

    typedef struct {
        bit         hi;
        logic [2:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    // Driver: set inputs while clk high, push expected high- and low-phase samples
    task automatic tick(input logic rst_v, input logic hold_v, input logic sel_v,
                        input string tag);
        item_t      it;
        logic [2:0] c;
        logic       run_m;
        @(posedge clk_in);
        #3;
        master_rst = rst_v;
        hold_req   = hold_v;
        ratio_sel  = sel_v;
        if (rst_v) begin
            foreach (sb[i]) sb[i].exp = 3'b000;   // asynchronous clear
        end
        run_m = !rst_v && !hold_v;
        if (rst_v) k = 0;
        else if (run_m) k = (k + 1) % 8;
        c = 3'((8 - k) % 8);
        it.tag = tag;
        it.hi  = 1'b1;
        it.exp = sel_v ? {c[1], c[0], run_m} : c;
        sb.push_back(it);
        it.hi  = 1'b0;
        it.exp = sel_v ? {c[1], c[0], 1'b0} : c;
        sb.push_back(it);
    endtask

    task automatic sample(input bit ph);
        item_t it;
        if (sb.size() > 0 && sb[0].hi == ph) begin
            it = sb.pop_front();
            checks++;
            if (div_out !== it.exp) begin
                failures++;
                $display("FAIL %s t=%0t actual=%b expected=%b", it.tag, $time, div_out, it.exp);
            end
        end
    endtask

    // Monitor: sample 2 ns after each edge
    initial begin
        forever begin
            @(posedge clk_in); #2; sample(1'b1);
            @(negedge clk_in); #2; sample(1'b0);
        end
    end

    // Pulse width monitor on the pass-through output
    realtime rise_t  = 0.0;
    bit      rise_ok = 1'b0;
    always @(posedge div_out[0]) begin
        rise_t  = $realtime;
        rise_ok = ratio_sel && !master_rst;
    end
    always @(negedge div_out[0]) begin
        if (rise_ok && ratio_sel && !master_rst) begin
            checks++;
            if ($realtime - rise_t < 4.9) begin
                failures++;
                $display("FAIL R8 runt pulse actual=%0t expected>=5", $realtime - rise_t);
            end
        end
        rise_ok = 1'b0;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R6: reset state
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, "R6");
        // R7: release taken on the falling edge, first count on next rise
        tick(1'b0, 1'b0, 1'b0, "R7");
        // R1, R3: slow set, several wraps
        for (int i = 0; i < 19; i++) tick(1'b0, 1'b0, 1'b0, "R1/R3");
        // R4: hold for five cycles
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b0, "R4");
        // R5: resume from held value
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, "R5");
        // R6: reset while hold is high
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1, "R6");
        // R9: new ratio set after reset release
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, 1'b1, "R9/R2");
        // R4, R8: hold toggling in fast set
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, 1'b1, 1'b1, "R4/R8");
            tick(1'b0, 1'b1, 1'b1, "R4/R8");
            tick(1'b0, 1'b0, 1'b1, "R5/R8");
        end
        // R7: release with hold high, then let it run
        tick(1'b1, 1'b0, 1'b0, "R6");
        tick(1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b0, "R7/R4");
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, "R7/R1");
        repeat (3) @(posedge clk_in);
        #8;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule